// File: doc/BRIEF.md
# Capture/Compare Timer

This block is a 16-bit up-counter with two event channels, controlled through a byte-wide register port. The counter advances on a tick taken either from a free-running divider of the bus clock (divide by 1 to 64 in powers of two) or from rising edges of an external clock pin. It restarts from zero once it has reached a programmable limit, so software can set the timer period.

Each channel owns one 16-bit value register and works in one of two modes. In capture mode, a chosen edge on the channel's input pin copies the counter into the value register. In compare mode, the channel acts on its output pin when the counter ticks while equal to the value register: it sets, clears or toggles the pin. Either kind of event raises the channel's flag, and the flag drives the channel's interrupt line when that line is enabled. Reading the high byte of a 16-bit register freezes the matching low byte, so software sees a consistent pair.

The register port has no data stream and no back-pressure. A write is taken on the clock edge that ends the cycle in which `bus_wr` is high. `bus_rdata` follows `bus_addr` in the same cycle. No access ever stalls.

Top module: `capcomp_timer`

## Requirements
- R1: After reset, the configuration register reads 0x00, both channel control registers read 0x00, both limit bytes read 0xFF, the counter starts at 0, and every pin output and interrupt line is 0.
- R2: Clock select values k = 0 to 6 (configuration register at address 0x0, bits 2:0) advance the counter once every 2^k bus clock cycles, with evenly spaced ticks.
- R3: Clock select value 7 advances the counter exactly once per rising edge of `ext_clk`, after a two-flop synchronizer, provided each level lasts at least two bus cycles. With no edges, the counter holds its value.
- R4: The limit register (high byte at 0x3, low byte at 0x4) sets the wrap point. A tick while the counter is at or above the limit loads 0; any other tick adds 1. A limit of 0 holds the counter at 0.
- R5: In capture mode (control bit 4 = 0), the edge field (control bits 3:2) selects the active edge: 01 rising, 10 falling, 11 both. An active edge loads the value register with the counter value two bus cycles after the cycle in which the pin changed, and sets the flag one cycle later.
- R6: In capture mode with edge field 00, pin edges change neither the value register nor the flag.
- R7: In compare mode (control bit 4 = 1), a tick in a cycle where the counter equals the value register sets the flag and acts on the pin at the end of that cycle. Edge field 01 toggles the pin, 10 clears it, 11 sets it, and 00 leaves it unchanged.
- R8: The flag (control bit 7) is set by any capture or compare event. Writing the control register with bit 7 = 0 clears it, and writing bit 7 = 1 leaves it unchanged. An event in the same cycle as a clearing write leaves the flag set.
- R9: A channel's interrupt line is high exactly when both its flag and its enable (control bit 6) are 1.
- R10: Control bit 5 is a stored spare mode bit on channel 0. On channel 1 it always reads 0.
- R11: A read strobe on a high-byte address (counter at 0x1, channel 0 at 0x6, channel 1 at 0x9) captures the low byte of that register in the same cycle. Later reads of the paired low-byte address (0x2, 0x7, 0xA) return that captured byte.
- R12: Channel 0 control is at 0x5 and channel 1 control at 0x8. The value registers are written bytewise at 0x6/0x7 and 0x9/0xA. Control bits 1:0 are stored and read back with no effect on behaviour.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 4 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (loads the low-byte holding register on high-byte reads) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| ext_clk | input | 1 | External count clock, asynchronous |
| ch_pin_in | input | 2 | Capture inputs, one per channel, asynchronous |
| ch_pin_out | output | 2 | Compare outputs, one per channel |
| ch_irq | output | 2 | Interrupt requests, one per channel |

## Verification
Each result has a fixed latency, and each check samples exactly at it.
- A register write is visible one cycle after its strobe. A read returns data in the cycle of its strobe.
- A capture holds the counter value from two cycles after the pin change, and the flag follows one cycle later.
- A compare action shows on the pin in the cycle after the counter sits at the target. The bench records its own cycle number at every counter read, so each capture value and each pin change is computed from cycle numbers. A same-cycle clear-versus-event race is set up by issuing the write on that cycle.
- Divider rates are measured as the spacing between successive compare toggles, which does not depend on divider phase. Wrap behaviour is checked arithmetically across a sweep of read gaps.

// File: rtl/capcomp_pkg.sv
package capcomp_pkg;
  localparam int unsigned CNT_W  = 16;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned ADDR_W = 4;

  localparam logic [ADDR_W-1:0] A_CFG    = 4'h0;
  localparam logic [ADDR_W-1:0] A_CNT_HI = 4'h1;
  localparam logic [ADDR_W-1:0] A_CNT_LO = 4'h2;
  localparam logic [ADDR_W-1:0] A_LIM_HI = 4'h3;
  localparam logic [ADDR_W-1:0] A_LIM_LO = 4'h4;
  localparam int unsigned CH_BASE   = 5;
  localparam int unsigned CH_STRIDE = 3;

  localparam logic [1:0] ACT_TGL = 2'b01;
  localparam logic [1:0] ACT_CLR = 2'b10;
  localparam logic [1:0] ACT_SET = 2'b11;

  typedef struct packed {
    logic       flag;
    logic       ie;
    logic       mode_b;
    logic       mode_a;
    logic [1:0] edge_sel;
    logic       spare1;
    logic       spare0;
  } chan_ctl_t;
endpackage

// File: rtl/capcomp_prescale.sv
module capcomp_prescale #(
  parameter int unsigned SEL_W       = 3,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] sel,
  input  logic             ext_clk,
  output logic             tick
);
  localparam int unsigned DIV_W = (1 << SEL_W) - 2;
  localparam logic [SEL_W-1:0] SEL_EXT = '1;

  logic [DIV_W-1:0]     div_q;
  logic [DIV_W-1:0]     mask;
  logic [SYNC_STAGES:0] ext_q;
  logic                 ext_rise;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q <= '0;
      ext_q <= '0;
    end else begin
      div_q <= div_q + DIV_W'(1);
      ext_q <= {ext_q[SYNC_STAGES-1:0], ext_clk};
    end
  end

  assign ext_rise = ext_q[SYNC_STAGES-1] & ~ext_q[SYNC_STAGES];

  always_comb begin
    mask = '0;
    for (int b = 0; b < int'(DIV_W); b++) mask[b] = (b < int'(sel));
    tick = (sel == SEL_EXT) ? ext_rise : ((div_q & mask) == mask);
  end

  // R2: at divide-by-2 two ticks never come back to back
  p_div2_spacing_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && sel == SEL_W'(1)) |=> (!tick || sel != SEL_W'(1)));
  // R3: a synchronized external edge yields a single-cycle tick
  p_ext_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && sel == SEL_EXT) |=> !(tick && sel == SEL_EXT));
endmodule

// File: rtl/capcomp_counter.sv
module capcomp_counter
  import capcomp_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [CNT_W-1:0] limit,
  output logic [CNT_W-1:0] cnt_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)                 cnt_q <= '0;
    else if (tick) begin
      if (cnt_q >= limit)       cnt_q <= '0;
      else                      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  p_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cnt_q >= limit) |=> cnt_q == '0);
  p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cnt_q < limit) |=> cnt_q == CNT_W'($past(cnt_q) + 1));
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt_q));
endmodule

// File: rtl/capcomp_channel.sv
module capcomp_channel
  import capcomp_pkg::*;
#(
  parameter bit          HAS_MODE_B  = 1'b1,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              wr_ctl,
  input  logic              wr_hi,
  input  logic              wr_lo,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              pin_in,
  output chan_ctl_t         ctl_q,
  output logic [CNT_W-1:0]  val_q,
  output logic              pin_out,
  output logic              irq
);
  logic [SYNC_STAGES:0] pin_q;
  logic rise, fall, cap_hit, cmp_hit, evt;

  always_ff @(posedge clk) begin
    if (!rst_n) pin_q <= '0;
    else        pin_q <= {pin_q[SYNC_STAGES-1:0], pin_in};
  end

  assign rise    = pin_q[SYNC_STAGES-1] & ~pin_q[SYNC_STAGES];
  assign fall    = ~pin_q[SYNC_STAGES-1] & pin_q[SYNC_STAGES];
  assign cap_hit = ~ctl_q.mode_a &
                   ((ctl_q.edge_sel[0] & rise) | (ctl_q.edge_sel[1] & fall));
  assign cmp_hit = ctl_q.mode_a & tick & (cnt == val_q);
  assign evt     = cap_hit | cmp_hit;
  assign irq     = ctl_q.flag & ctl_q.ie;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q <= '0;
    end else begin
      if (wr_ctl) begin
        ctl_q.ie       <= wdata[6];
        ctl_q.mode_b   <= HAS_MODE_B ? wdata[5] : 1'b0;
        ctl_q.mode_a   <= wdata[4];
        ctl_q.edge_sel <= wdata[3:2];
        ctl_q.spare1   <= wdata[1];
        ctl_q.spare0   <= wdata[0];
      end
      if (evt)                    ctl_q.flag <= 1'b1;
      else if (wr_ctl && !wdata[7]) ctl_q.flag <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      val_q <= '0;
    end else if (cap_hit) begin
      val_q <= cnt;
    end else begin
      if (wr_hi) val_q[CNT_W-1:BYTE_W] <= wdata;
      if (wr_lo) val_q[BYTE_W-1:0]     <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pin_out <= 1'b0;
    else if (cmp_hit) begin
      case (ctl_q.edge_sel)
        ACT_TGL: pin_out <= ~pin_out;
        ACT_CLR: pin_out <= 1'b0;
        ACT_SET: pin_out <= 1'b1;
        default: pin_out <= pin_out;
      endcase
    end
  end

  p_cap_latch_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cap_hit |=> val_q == $past(cnt));
  p_cap_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_q.mode_a && ctl_q.edge_sel == 2'b00 && !wr_hi && !wr_lo) |=> $stable(val_q));
  p_cmp_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_hit && ctl_q.edge_sel == ACT_SET) |=> pin_out);
  p_cmp_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_hit && ctl_q.edge_sel == ACT_CLR) |=> !pin_out);
  p_cmp_tgl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_hit && ctl_q.edge_sel == ACT_TGL) |=> pin_out != $past(pin_out));
  p_evt_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> ctl_q.flag);
  p_flag_w1_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctl && wdata[7] && !ctl_q.flag && !evt) |=> !ctl_q.flag);
  p_irq_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_q.ie |-> !irq);

  generate
    if (!HAS_MODE_B) begin : g_no_mode_b
      p_no_mode_b_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_q.mode_b);
    end
  endgenerate
endmodule

// File: rtl/capcomp_timer.sv
module capcomp_timer
  import capcomp_pkg::*;
#(
  parameter int unsigned SEL_W       = 3,
  parameter int unsigned NCH         = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [BYTE_W-1:0] bus_rdata,
  input  logic              ext_clk,
  input  logic [NCH-1:0]    ch_pin_in,
  output logic [NCH-1:0]    ch_pin_out,
  output logic [NCH-1:0]    ch_irq
);
  logic [SEL_W-1:0]  sel_q;
  logic [CNT_W-1:0]  lim_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [BYTE_W-1:0] lo_hold;
  logic              tick;
  chan_ctl_t         ctl_a [NCH];
  logic [CNT_W-1:0]  val_a [NCH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q <= '0;
      lim_q <= '1;
    end else if (bus_wr) begin
      if (bus_addr == A_CFG)    sel_q <= bus_wdata[SEL_W-1:0];
      if (bus_addr == A_LIM_HI) lim_q[CNT_W-1:BYTE_W] <= bus_wdata;
      if (bus_addr == A_LIM_LO) lim_q[BYTE_W-1:0]     <= bus_wdata;
    end
  end

  capcomp_prescale #(.SEL_W(SEL_W), .SYNC_STAGES(SYNC_STAGES)) u_pre (
    .clk(clk), .rst_n(rst_n), .sel(sel_q), .ext_clk(ext_clk), .tick(tick)
  );

  capcomp_counter u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .limit(lim_q), .cnt_q(cnt_q)
  );

  generate
    for (genvar i = 0; i < int'(NCH); i++) begin : g_ch
      localparam logic [ADDR_W-1:0] A_CTL = ADDR_W'(CH_BASE + CH_STRIDE * i);
      localparam logic [ADDR_W-1:0] A_HI  = ADDR_W'(CH_BASE + CH_STRIDE * i + 1);
      localparam logic [ADDR_W-1:0] A_LO  = ADDR_W'(CH_BASE + CH_STRIDE * i + 2);
      capcomp_channel #(.HAS_MODE_B(i == 0), .SYNC_STAGES(SYNC_STAGES)) u_ch (
        .clk(clk), .rst_n(rst_n), .tick(tick), .cnt(cnt_q),
        .wr_ctl(bus_wr && bus_addr == A_CTL),
        .wr_hi(bus_wr && bus_addr == A_HI),
        .wr_lo(bus_wr && bus_addr == A_LO),
        .wdata(bus_wdata), .pin_in(ch_pin_in[i]),
        .ctl_q(ctl_a[i]), .val_q(val_a[i]),
        .pin_out(ch_pin_out[i]), .irq(ch_irq[i])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_hold <= '0;
    end else if (bus_rd) begin
      if (bus_addr == A_CNT_HI) lo_hold <= cnt_q[BYTE_W-1:0];
      for (int c = 0; c < int'(NCH); c++)
        if (bus_addr == ADDR_W'(CH_BASE + CH_STRIDE * c + 1)) lo_hold <= val_a[c][BYTE_W-1:0];
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CFG:    bus_rdata = BYTE_W'(sel_q);
      A_CNT_HI: bus_rdata = cnt_q[CNT_W-1:BYTE_W];
      A_CNT_LO: bus_rdata = lo_hold;
      A_LIM_HI: bus_rdata = lim_q[CNT_W-1:BYTE_W];
      A_LIM_LO: bus_rdata = lim_q[BYTE_W-1:0];
      default: begin
        for (int c = 0; c < int'(NCH); c++) begin
          if (bus_addr == ADDR_W'(CH_BASE + CH_STRIDE * c))     bus_rdata = ctl_a[c];
          if (bus_addr == ADDR_W'(CH_BASE + CH_STRIDE * c + 1)) bus_rdata = val_a[c][CNT_W-1:BYTE_W];
          if (bus_addr == ADDR_W'(CH_BASE + CH_STRIDE * c + 2)) bus_rdata = lo_hold;
        end
      end
    endcase
  end

  // R11: a high-byte counter read freezes the low byte of that same cycle
  p_lo_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == A_CNT_HI) |=> lo_hold == $past(cnt_q[BYTE_W-1:0]));
endmodule

// File: tb/test_capcomp_timer.sv
module test_capcomp_timer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] bus_addr = '0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       ext_clk = 1'b0;
  logic [1:0] ch_pin_in = '0;
  logic [1:0] ch_pin_out;
  logic [1:0] ch_irq;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  capcomp_timer i_capcomp_timer (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ext_clk(ext_clk),
    .ch_pin_in(ch_pin_in), .ch_pin_out(ch_pin_out), .ch_irq(ch_irq)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd8(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    @(posedge clk);
    #1 bus_rd = 1'b0;
  endtask

  task automatic rd16(input logic [3:0] a, output logic [15:0] v, output int t);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    #1 v[15:8] = bus_rdata; t = cyc;
    @(negedge clk);
    bus_addr = 4'(a + 1);
    #1 v[7:0] = bus_rdata;
    @(posedge clk);
    #1 bus_rd = 1'b0;
  endtask

  task automatic wait_toggle(output int t);
    logic p;
    p = ch_pin_out[0];
    do @(negedge clk); while (ch_pin_out[0] == p);
    t = cyc;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_up();
  end

  initial begin
    logic [7:0]  b;
    logic [15:0] v1, v2, vold, vcap;
    int t1, t2, ta, tb;

    repeat (4) @(negedge clk);
    chk("R1", "pin_out during reset", int'(ch_pin_out), 0);
    rst_n = 1'b1;

    // R1 reset values
    rd8(4'h0, b); chk("R1", "clock select", b, 0);
    rd8(4'h5, b); chk("R1", "ch0 control", b, 0);
    rd8(4'h8, b); chk("R1", "ch1 control", b, 0);
    rd8(4'h3, b); chk("R1", "limit high", b, 8'hFF);
    rd8(4'h4, b); chk("R1", "limit low", b, 8'hFF);
    rd8(4'h1, b); chk("R1", "counter high", b, 0);
    chk("R1", "irq", int'(ch_irq), 0);
    chk("R1", "pin_out", int'(ch_pin_out), 0);

    // R10 / R12 control readback, R8 flag ignores a written 1
    wr(4'h5, 8'hA3); rd8(4'h5, b); chk("R10", "ch0 control readback", b, 8'h23);
    wr(4'h8, 8'hAF); rd8(4'h8, b); chk("R10", "ch1 mode_b reads 0", b, 8'h0F);
    wr(4'h5, 8'h00); wr(4'h8, 8'h00);
    wr(4'h0, 8'h05); rd8(4'h0, b); chk("R12", "clock select readback", b, 5);
    wr(4'h0, 8'h00);

    // R4 wrap at limit 5, then limit 0
    wr(4'h3, 8'h00); wr(4'h4, 8'h05);
    repeat (10) @(negedge clk);
    for (int n = 0; n < 13; n++) begin
      rd16(4'h1, v1, t1);
      repeat (n) @(negedge clk);
      rd16(4'h1, v2, t2);
      chk("R4", $sformatf("wrap limit 5 gap %0d", t2 - t1), v2, (int'(v1) + t2 - t1) % 6);
    end
    wr(4'h4, 8'h00);
    repeat (3) @(negedge clk);
    for (int n = 0; n < 3; n++) begin
      rd16(4'h1, v1, t1);
      chk("R4", "limit 0 holds at 0", v1, 0);
    end
    wr(4'h3, 8'hFF); wr(4'h4, 8'hFF);

    // R11 coherent read: the low byte is frozen at the high-byte read
    rd16(4'h1, v1, t1);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = 4'h1;
    #1 b = bus_rdata; t2 = cyc;
    @(posedge clk); #1 bus_rd = 1'b0;
    chk("R11", "counter high", b, ((int'(v1) + t2 - t1) >> 8) & 255);
    repeat (7) @(negedge clk);
    rd8(4'h2, b);
    chk("R11", "frozen low byte", b, (int'(v1) + t2 - t1) & 255);

    // R2 divider rates via compare toggle period (limit 3, target 0)
    wr(4'h3, 8'h00); wr(4'h4, 8'h03);
    wr(4'h6, 8'h00); wr(4'h7, 8'h00);
    wr(4'h5, 8'h54);
    for (int k = 0; k < 7; k++) begin
      wr(4'h0, 8'(k));
      wait_toggle(ta); wait_toggle(ta);
      wait_toggle(tb);
      chk("R2", $sformatf("toggle period sel %0d", k), tb - ta, 4 << k);
      chk("R9", "irq on compare with enable", int'(ch_irq[0]), 1);
    end
    wr(4'h0, 8'h00);
    wr(4'h5, 8'h00);
    chk("R9", "irq cleared with flag", int'(ch_irq[0]), 0);
    wr(4'h3, 8'hFF); wr(4'h4, 8'hFF);

    // R3 external clock
    wr(4'h0, 8'h07);
    repeat (5) @(negedge clk);
    rd16(4'h1, v1, t1);
    for (int i = 0; i < 10; i++) begin
      ext_clk = 1'b1; repeat (3) @(negedge clk);
      ext_clk = 1'b0; repeat (3) @(negedge clk);
    end
    repeat (5) @(negedge clk);
    rd16(4'h1, v2, t2);
    chk("R3", "ten external edges", v2, (int'(v1) + 10) & 16'hFFFF);
    repeat (20) @(negedge clk);
    rd16(4'h1, v1, t1);
    chk("R3", "no edges holds counter", v1, v2);
    wr(4'h0, 8'h00);

    // R5 / R6 capture sweep on channel 1
    for (int es = 0; es < 4; es++) begin
      for (int dir = 0; dir < 2; dir++) begin
        bit active;
        active = (es == 3) || (es == 1 && dir == 0) || (es == 2 && dir == 1);
        ch_pin_in[1] = (dir == 1);
        repeat (5) @(negedge clk);
        wr(4'h8, 8'(8'h40 | (es << 2)));
        rd16(4'h9, vold, t1);
        @(negedge clk);
        ch_pin_in[1] = (dir == 0);
        bus_rd = 1'b1; bus_addr = 4'h1;
        #1 vcap[15:8] = bus_rdata;
        @(negedge clk);
        bus_addr = 4'h2;
        #1 vcap[7:0] = bus_rdata;
        @(posedge clk); #1 bus_rd = 1'b0;
        repeat (4) @(negedge clk);
        rd8(4'h8, b);
        chk(active ? "R5" : "R6", $sformatf("flag edge %0d dir %0d", es, dir), b[7], active);
        chk("R9", "capture irq", int'(ch_irq[1]), active);
        rd16(4'h9, v2, t2);
        chk(active ? "R5" : "R6", $sformatf("value edge %0d dir %0d", es, dir), v2,
            active ? ((int'(vcap) + 2) & 16'hFFFF) : int'(vold));
      end
    end
    wr(4'h8, 8'h00);

    // R7 / R8 / R9 compare actions on channel 0
    begin
      int acts [5] = '{3, 1, 1, 2, 0};
      logic pb, pe;
      for (int i = 0; i < 6; i++) begin
        int es, ie;
        logic [15:0] tgt;
        logic [7:0] cv;
        es = (i < 5) ? acts[i] : 0;
        ie = (i == 5) ? 1 : (i % 2);
        cv = 8'(8'h10 | (es << 2) | (ie << 6));
        wr(4'h5, 8'h00);
        pb = ch_pin_out[0];
        rd16(4'h1, v1, t1);
        tgt = 16'(v1 + 20);
        wr(4'h6, tgt[15:8]);
        wr(4'h7, tgt[7:0]);
        wr(4'h5, cv);
        while (cyc != t1 + 20) @(negedge clk);
        chk("R7", "pin before match", int'(ch_pin_out[0]), int'(pb));
        if (i == 5) begin
          bus_wr = 1'b1; bus_addr = 4'h5; bus_wdata = cv;
        end
        @(negedge clk);
        bus_wr = 1'b0;
        case (es)
          3: pe = 1'b1;
          2: pe = 1'b0;
          1: pe = ~pb;
          default: pe = pb;
        endcase
        chk("R7", $sformatf("pin after action %0d", es), int'(ch_pin_out[0]), int'(pe));
        chk("R9", $sformatf("compare irq enable %0d", ie), int'(ch_irq[0]), ie);
        rd8(4'h5, b);
        chk(i == 5 ? "R8" : "R7", "flag after match", b[7], 1);
        if (i == 1) begin
          wr(4'h5, 8'(cv | 8'h80));
          rd8(4'h5, b); chk("R8", "write 1 keeps flag", b[7], 1);
          wr(4'h5, cv);
          rd8(4'h5, b); chk("R8", "write 0 clears flag", b[7], 0);
          chk("R9", "irq drops with flag", int'(ch_irq[0]), 0);
        end
      end
    end

    finish_up();
  end
endmodule